// File: doc/BRIEF.md
# Multi-Channel Mailbox Message Sequencer

This block is the host-side engine of a shared-RAM mailbox between a host and a coprocessor. The mailbox has seven channels. Each channel has one 32-byte outgoing buffer, one 32-byte incoming buffer and a state byte for each direction. A host request either queues an outgoing message on a channel or completes an incoming message that a consumer has finished with. The engine copies bytes into the shared RAM over a byte-wide port and pulses an attention line toward the coprocessor.

The coprocessor raises two event flags: send-complete and receive-new. While either flag is set, the engine runs a service loop. The send-complete flag is handled first. The engine clears that flag, visits the outgoing states of channels 0 to 6 in order, and retires every channel it finds in COMPLETE. Retiring a channel means writing IDLE, reading the reply back from the same buffer and handing it to the host. If another message is pending on that channel, the engine sends it at once. The receive-new flag is handled second, in the same way. The engine clears the flag, visits the incoming states in order, reads every channel in NEW, marks it RCVD and hands the message to the host. If no consumer is attached to that channel, the engine answers by itself with an all-zero reply. After both scans the flags are sampled again, and the loop repeats while either one is set.

The sequencer is a single enumerated state machine with these states:
- F_IDLE: waits for a request or an event.
- F_LOOP: samples the flags.
- F_CLR: clears one flag and rewinds the channel index.
- F_STRD, then F_STCHK: read and test a state byte.
- F_ACKWR: writes IDLE or RCVD.
- F_BURST: reads 32 bytes.
- F_EMIT: presents the message or reply to the host.
- F_NXRD, then F_NXCHK: re-read the state before a follow-on send.
- F_WBUF, then F_WST, then F_ATTN: write 32 bytes, write the state byte, pulse attention.
- F_NEXT: advances the channel index or ends the pass.

The transitions are:
- F_IDLE goes to F_LOOP on any event flag, and to F_WBUF on an accepted send to an empty queue or on a host completion.
- F_LOOP goes back to F_IDLE when no flag is set, and to F_CLR otherwise.
- F_STCHK goes to F_ACKWR on an outgoing COMPLETE, to F_BURST on an incoming NEW, and to F_NEXT otherwise.
- F_EMIT goes to F_NXRD when a send is still queued, to F_WBUF for an incoming channel with no consumer, and to F_NEXT otherwise.
- F_NXCHK goes to F_WBUF when the state reads IDLE, and to F_NEXT otherwise.
- F_ATTN goes to F_NEXT inside a scan, and to F_IDLE otherwise.
- F_NEXT goes to F_STRD for the next channel. After channel 6 it goes to F_CLR for the receive scan, or to F_LOOP.

Top module: `mbx_seq_top`

## Requirements
- R1: Channel c's outgoing buffer is at byte address c*32 and its incoming buffer is at 256+c*32. The outgoing state bytes are at 512+c and the incoming state bytes are at 520+c. Buffer byte i sits at bits [8i+7:8i] of every 256-bit data port.
- R2: A send to an idle channel writes all 32 buffer bytes, then writes state NEW (0x01). Attention pulses for one cycle on the cycle after that state write. These are 33 RAM writes and one attention pulse.
- R3: Buffer bytes at positions at or above the request length are written as zero, so a length of 0 gives an all-zero buffer.
- R4: A request whose channel is 7 or more, or whose length exceeds 32, gets response code 1 (error). It causes no RAM write and no attention pulse.
- R5: Each channel holds at most two messages: the one in flight plus one waiting. A send to a channel that already holds two gets response code 2 (busy) and no RAM write. An accepted send gets code 0.
- R6: During the send scan, a channel whose outgoing state is COMPLETE (0x03) is set to IDLE (0x00). Its 32-byte reply is read from the same outgoing buffer and presented with out_dir=0 and the channel number.
- R7: After a channel is retired, a waiting message on it is sent at once if its state reads IDLE. This follows R2, and messages leave in the order they were accepted.
- R8: During the receive scan, a channel whose incoming state is NEW (0x01) is read and presented with out_dir=1. Its state is then set to RCVD (0x02).
- R9: If rx_attach[c] is 0, a received message on channel c is answered by the engine. It writes 32 zero bytes to the incoming buffer, writes state COMPLETE (0x03) and pulses attention.
- R10: A completion request (req_op=1) writes the padded reply to the channel's incoming buffer, writes state COMPLETE and pulses attention.
- R11: Each event flag (evt_clr bit 0 for send-complete, bit 1 for receive-new) is cleared before its scan. The loop repeats while either flag is set, so an event raised after its scan is still serviced.
- R12: Within one pass, send-complete handling comes before receive handling, and channels are visited in ascending order.
- R13: After reset, req_ready is 1 and attn, ram_we, rsp_valid, out_valid and evt_clr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Engine idle with no pending event; request taken this cycle |
| req_op | input | 1 | 0 = queue a send, 1 = complete a received message |
| req_chan | input | 4 | Channel number |
| req_len | input | 7 | Valid byte count of req_data |
| req_data | input | 256 | Message or reply bytes |
| rsp_valid | output | 1 | One-cycle response pulse, one cycle after acceptance |
| rsp_code | output | 2 | 0 ok, 1 error, 2 busy |
| out_valid | output | 1 | Reply or received message is valid |
| out_dir | output | 1 | 0 = send reply, 1 = received message |
| out_chan | output | 4 | Channel of out_data |
| out_data | output | 256 | Reply or message bytes |
| rx_attach | input | 7 | Per channel: a consumer takes received messages |
| evt_flags | input | 2 | Bit 0 send-complete, bit 1 receive-new |
| evt_clr | output | 2 | One-cycle clear pulse for the matching flag |
| ram_addr | output | 10 | Shared RAM byte address |
| ram_we | output | 1 | Shared RAM write enable |
| ram_wdata | output | 8 | Shared RAM write data |
| ram_rdata | input | 8 | Shared RAM read data, one cycle after the address |
| attn | output | 1 | Attention pulse to the coprocessor |

## Verification
The send path is exercised with a full-length message, short and zero-length messages, out-of-range channels and lengths, and a third message to a busy channel. Together these separate padding, rejection and queue back-pressure by their RAM write counts and attention counts. A send-complete event on a channel with a waiting message shows that the reply is read back before the queued message replaces it. A receive event on one attached and one unattached channel separates the plain RCVD acknowledgement from the automatic zero reply. A final pattern raises both flags together, then raises a receive event on a channel below the one just served. The order of the outputs shows that send-complete is handled before receive, and that the loop runs a second pass.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [7:0] {
        MB_IDLE = 8'h00,
        MB_NEW  = 8'h01,
        MB_RCVD = 8'h02,
        MB_DONE = 8'h03
    } mb_state_e;

    typedef enum logic [1:0] {
        RSP_OK   = 2'd0,
        RSP_ERR  = 2'd1,
        RSP_BUSY = 2'd2
    } rsp_e;

    localparam logic OP_SEND = 1'b0;
    localparam logic OP_DONE = 1'b1;
endpackage

// File: rtl/mbx_pad.sv
module mbx_pad #(
    parameter int MSG_BYTES = 32,
    parameter int LEN_W     = 7,
    localparam int MSG_W    = MSG_BYTES * 8
) (
    input  logic [MSG_W-1:0] din,
    input  logic [LEN_W-1:0] len,
    output logic [MSG_W-1:0] dout
);
    for (genvar i = 0; i < MSG_BYTES; i++) begin : g_byte
        assign dout[8*i +: 8] = (LEN_W'(i) < len) ? din[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/mbx_send_queue.sv
module mbx_send_queue #(
    parameter int N_CHAN = 7,
    parameter int DEPTH  = 2,
    parameter int DATA_W = 256,
    parameter int CH_W   = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int QC_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [CH_W-1:0]   push_chan,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic [CH_W-1:0]   pop_chan,
    input  logic [CH_W-1:0]   sel_chan,
    output logic [QC_W-1:0]   sel_cnt,
    output logic [DATA_W-1:0] sel_head
);
    logic [QC_W-1:0]   cnt_all  [N_CHAN];
    logic [DATA_W-1:0] head_all [N_CHAN];

    for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
        logic [DATA_W-1:0] slot [DEPTH];
        logic [PTR_W-1:0]  rp;
        logic [PTR_W-1:0]  wp;
        logic [QC_W-1:0]   n;
        logic              do_push;
        logic              do_pop;

        assign do_push = push && (push_chan == CH_W'(c));
        assign do_pop  = pop && (pop_chan == CH_W'(c));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rp <= '0;
                wp <= '0;
                n  <= '0;
            end else begin
                if (do_push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
                if (do_pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
                n <= n + QC_W'(do_push) - QC_W'(do_pop);
            end
        end

        always_ff @(posedge clk) begin
            if (do_push) slot[wp] <= push_data;
        end

        assign cnt_all[c]  = n;
        assign head_all[c] = slot[rp];

        // R5: a push never lands on a full channel queue
        p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
            do_push |-> (n < QC_W'(DEPTH)));
        // R7: a retire only pops a channel that holds a message
        p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            do_pop |-> (n != '0));
    end

    always_comb begin
        sel_cnt  = '0;
        sel_head = '0;
        for (int c = 0; c < N_CHAN; c++) begin
            if (sel_chan == CH_W'(c)) begin
                sel_cnt  = cnt_all[c];
                sel_head = head_all[c];
            end
        end
    end
endmodule

// File: rtl/mbx_seq_top.sv
module mbx_seq_top
    import mbx_pkg::*;
#(
    parameter int N_CHAN        = 7,
    parameter int MSG_BYTES     = 32,
    parameter int QDEPTH        = 2,
    parameter int ADDR_W        = 10,
    parameter int SEND_BUF_BASE = 0,
    parameter int RECV_BUF_BASE = 256,
    parameter int SEND_ST_BASE  = 512,
    parameter int RECV_ST_BASE  = 520,
    localparam int MSG_W = MSG_BYTES * 8,
    localparam int CH_W  = $clog2(N_CHAN) + 1,
    localparam int LEN_W = $clog2(MSG_BYTES) + 2,
    localparam int IDX_W = $clog2(MSG_BYTES),
    localparam int CNT_W = IDX_W + 1,
    localparam int QC_W  = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [MSG_W-1:0]  req_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              out_valid,
    output logic              out_dir,
    output logic [CH_W-1:0]   out_chan,
    output logic [MSG_W-1:0]  out_data,
    input  logic [N_CHAN-1:0] rx_attach,
    input  logic [1:0]        evt_flags,
    output logic [1:0]        evt_clr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              attn
);
    typedef enum logic [3:0] {
        F_IDLE, F_LOOP, F_CLR, F_STRD, F_STCHK, F_ACKWR, F_BURST, F_EMIT,
        F_NXRD, F_NXCHK, F_WBUF, F_WST, F_ATTN, F_NEXT
    } fsm_e;

    fsm_e st, st_nx;

    logic              dir;
    logic [CH_W-1:0]   chan;
    logic [CNT_W-1:0]  cnt;
    logic [MSG_W-1:0]  wbuf;
    logic [MSG_W-1:0]  rbuf;
    logic [1:0]        ev;
    logic              ret_scan;
    logic [7:0]        wst_code;

    logic              req_bad;
    logic              accept;
    logic [MSG_W-1:0]  padded;
    logic [CH_W-1:0]   q_sel;
    logic [QC_W-1:0]   q_cnt;
    logic [MSG_W-1:0]  q_head;
    logic              q_full;
    logic              q_push;
    logic              q_pop;
    logic              attached;
    logic [ADDR_W-1:0] st_addr;
    logic [ADDR_W-1:0] buf_addr;

    assign req_bad  = (int'(req_chan) >= N_CHAN) || (int'(req_len) > MSG_BYTES);
    assign req_ready = (st == F_IDLE) && (evt_flags == 2'b00);
    assign accept   = req_valid && req_ready;
    assign q_sel    = (st == F_IDLE && !req_bad) ? req_chan : chan;
    assign q_full   = (q_cnt == QC_W'(QDEPTH));
    assign q_push   = accept && (req_op == OP_SEND) && !req_bad && !q_full;
    assign q_pop    = (st == F_EMIT) && !dir;
    assign attached = |(rx_attach & (N_CHAN'(1) << chan));

    assign st_addr  = ADDR_W'((dir ? RECV_ST_BASE : SEND_ST_BASE) + int'(chan));
    assign buf_addr = ADDR_W'((dir ? RECV_BUF_BASE : SEND_BUF_BASE)
                      + int'(chan) * MSG_BYTES + int'(cnt[IDX_W-1:0]));

    mbx_pad #(.MSG_BYTES(MSG_BYTES), .LEN_W(LEN_W)) i_pad (
        .din (req_data),
        .len (req_len),
        .dout(padded)
    );

    mbx_send_queue #(.N_CHAN(N_CHAN), .DEPTH(QDEPTH), .DATA_W(MSG_W), .CH_W(CH_W)) i_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .push_chan(req_chan),
        .push_data(padded),
        .pop      (q_pop),
        .pop_chan (chan),
        .sel_chan (q_sel),
        .sel_cnt  (q_cnt),
        .sel_head (q_head)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= F_IDLE;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            F_IDLE: begin
                if (evt_flags != 2'b00)
                    st_nx = F_LOOP;
                else if (accept && !req_bad &&
                         (req_op == OP_DONE || (!q_full && q_cnt == '0)))
                    st_nx = F_WBUF;
            end
            F_LOOP:  st_nx = (evt_flags == 2'b00) ? F_IDLE : F_CLR;
            F_CLR:   st_nx = F_STRD;
            F_STRD:  st_nx = F_STCHK;
            F_STCHK: begin
                if (!dir && ram_rdata == MB_DONE)     st_nx = F_ACKWR;
                else if (dir && ram_rdata == MB_NEW)  st_nx = F_BURST;
                else                                  st_nx = F_NEXT;
            end
            F_ACKWR: st_nx = dir ? F_EMIT : F_BURST;
            F_BURST: st_nx = (cnt == CNT_W'(MSG_BYTES)) ? (dir ? F_ACKWR : F_EMIT) : F_BURST;
            F_EMIT: begin
                if (dir) st_nx = attached ? F_NEXT : F_WBUF;
                else     st_nx = (q_cnt > QC_W'(1)) ? F_NXRD : F_NEXT;
            end
            F_NXRD:  st_nx = F_NXCHK;
            F_NXCHK: st_nx = (ram_rdata == MB_IDLE) ? F_WBUF : F_NEXT;
            F_WBUF:  st_nx = (cnt == CNT_W'(MSG_BYTES - 1)) ? F_WST : F_WBUF;
            F_WST:   st_nx = F_ATTN;
            F_ATTN:  st_nx = ret_scan ? F_NEXT : F_IDLE;
            F_NEXT: begin
                if (chan == CH_W'(N_CHAN - 1))
                    st_nx = (!dir && ev[1]) ? F_CLR : F_LOOP;
                else
                    st_nx = F_STRD;
            end
            default: st_nx = F_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir       <= 1'b0;
            chan      <= '0;
            cnt       <= '0;
            wbuf      <= '0;
            rbuf      <= '0;
            ev        <= 2'b00;
            ret_scan  <= 1'b0;
            wst_code  <= MB_IDLE;
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_OK;
        end else begin
            rsp_valid <= accept;
            if (accept)
                rsp_code <= req_bad ? RSP_ERR
                          : (req_op == OP_SEND && q_full) ? RSP_BUSY : RSP_OK;

            cnt <= ((st == F_BURST || st == F_WBUF) && st_nx == st) ? cnt + 1'b1 : '0;

            if (st == F_BURST && cnt != '0)
                rbuf[8*(int'(cnt) - 1) +: 8] <= ram_rdata;

            unique case (st)
                F_IDLE: begin
                    if (accept && !req_bad) begin
                        dir      <= req_op;
                        chan     <= req_chan;
                        wbuf     <= padded;
                        wst_code <= (req_op == OP_SEND) ? MB_NEW : MB_DONE;
                        ret_scan <= 1'b0;
                    end
                end
                F_LOOP: begin
                    ev  <= evt_flags;
                    dir <= !evt_flags[0];
                end
                F_CLR:  chan <= '0;
                F_EMIT: begin
                    wbuf     <= '0;
                    wst_code <= MB_DONE;
                    ret_scan <= 1'b1;
                end
                F_NXCHK: begin
                    wbuf     <= q_head;
                    wst_code <= MB_NEW;
                    ret_scan <= 1'b1;
                end
                F_NEXT: begin
                    if (chan == CH_W'(N_CHAN - 1)) begin
                        if (!dir && ev[1]) dir <= 1'b1;
                    end else begin
                        chan <= chan + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = 8'h00;
        attn      = 1'b0;
        evt_clr   = 2'b00;
        out_valid = 1'b0;
        unique case (st)
            F_CLR:  evt_clr = dir ? 2'b10 : 2'b01;
            F_STRD, F_NXRD: ram_addr = st_addr;
            F_ACKWR: begin
                ram_we    = 1'b1;
                ram_addr  = st_addr;
                ram_wdata = dir ? MB_RCVD : MB_IDLE;
            end
            F_BURST: ram_addr = buf_addr;
            F_EMIT:  out_valid = 1'b1;
            F_WBUF: begin
                ram_we    = 1'b1;
                ram_addr  = buf_addr;
                ram_wdata = wbuf[8*int'(cnt[IDX_W-1:0]) +: 8];
            end
            F_WST: begin
                ram_we    = 1'b1;
                ram_addr  = st_addr;
                ram_wdata = wst_code;
            end
            F_ATTN: attn = 1'b1;
            default: ;
        endcase
    end

    assign out_dir  = dir;
    assign out_chan = chan;
    assign out_data = rbuf;

    // R2: attention only follows a state-byte write
    p_attn_after_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        attn |-> ($past(ram_we) && int'($past(ram_addr)) >= SEND_ST_BASE));
    // R9: attention is a single-cycle pulse
    p_attn_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        attn |=> !attn);
    // R4: an error response is never accompanied by a RAM write
    p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_ERR) |-> !ram_we);
    // R11: only one flag is cleared at a time
    p_clr_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_clr));
    // R12: outputs only ever name a real channel
    p_out_chan_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_chan) < N_CHAN));
endmodule

// File: tb/test_mbx_seq_top.sv
module test_mbx_seq_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_op = 1'b0;
    logic [3:0]   req_chan = '0;
    logic [6:0]   req_len = '0;
    logic [255:0] req_data = '0;
    logic         rsp_valid;
    logic [1:0]   rsp_code;
    logic         out_valid;
    logic         out_dir;
    logic [3:0]   out_chan;
    logic [255:0] out_data;
    logic [6:0]   rx_attach = '0;
    logic [1:0]   flags;
    logic [1:0]   evt_clr;
    logic [9:0]   ram_addr;
    logic         ram_we;
    logic [7:0]   ram_wdata;
    logic [7:0]   ram_rdata;
    logic         attn;

    always #5 clk = ~clk;

    mbx_seq_top i_mbx_seq_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_chan(req_chan), .req_len(req_len), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .out_valid(out_valid), .out_dir(out_dir), .out_chan(out_chan), .out_data(out_data),
        .rx_attach(rx_attach), .evt_flags(flags), .evt_clr(evt_clr),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .attn(attn)
    );

    // coprocessor-side model: shared RAM and sticky event flags
    logic [7:0]   mem [1024];
    logic         bwe = 1'b0;
    logic [9:0]   baddr = '0;
    logic [7:0]   bwdata = '0;
    logic [1:0]   fset = 2'b00;
    int           attn_n, wr_n, out_n;
    logic         ev_dir  [8];
    logic [3:0]   ev_chan [8];
    logic [255:0] ev_data [8];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 1024; k++) mem[k] <= 8'h00;
            flags  <= 2'b00;
            attn_n <= 0;
            wr_n   <= 0;
            out_n  <= 0;
        end else begin
            if (ram_we) begin mem[ram_addr] <= ram_wdata; wr_n <= wr_n + 1; end
            if (bwe) mem[baddr] <= bwdata;
            flags <= (flags & ~evt_clr) | fset;
            if (attn) attn_n <= attn_n + 1;
            if (out_valid) begin
                if (out_n < 8) begin
                    ev_dir[out_n]  <= out_dir;
                    ev_chan[out_n] <= out_chan;
                    ev_data[out_n] <= out_data;
                end
                out_n <= out_n + 1;
            end
        end
        ram_rdata <= mem[ram_addr];
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_msg(input logic [7:0] seed);
        logic [255:0] m;
        for (int i = 0; i < 32; i++) m[8*i +: 8] = seed + 8'(i);
        return m;
    endfunction

    function automatic logic [255:0] exp_msg(input logic [7:0] seed, input int len);
        logic [255:0] m;
        for (int i = 0; i < 32; i++) m[8*i +: 8] = (i < len) ? seed + 8'(i) : 8'h00;
        return m;
    endfunction

    function automatic logic [255:0] buf_at(input int base);
        logic [255:0] m;
        for (int i = 0; i < 32; i++) m[8*i +: 8] = mem[base + i];
        return m;
    endfunction

    task automatic bwrite(input int a, input logic [7:0] d);
        bwe = 1'b1; baddr = 10'(a); bwdata = d;
        @(negedge clk);
        bwe = 1'b0;
    endtask

    task automatic fill(input int base, input logic [7:0] seed);
        for (int i = 0; i < 32; i++) bwrite(base + i, seed + 8'(i));
    endtask

    task automatic raise(input logic [1:0] f);
        fset = f;
        @(negedge clk);
        fset = 2'b00;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic request(input logic op, input int ch, input int len,
                           input logic [7:0] seed, output logic [1:0] code);
        while (!req_ready) @(negedge clk);
        req_op = op; req_chan = 4'(ch); req_len = 7'(len); req_data = mk_msg(seed);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R13 response strobe", 256'(rsp_valid), 256'(1));
        code = rsp_code;
    endtask

    // {chan[4], len[7], seed[8], exp_code[2], sent[1]}
    localparam logic [21:0] VEC [8] = '{
        {4'd0,  7'd32, 8'h10, 2'd0, 1'b1},
        {4'd6,  7'd5,  8'h40, 2'd0, 1'b1},
        {4'd7,  7'd4,  8'h20, 2'd1, 1'b0},
        {4'd2,  7'd33, 8'h21, 2'd1, 1'b0},
        {4'd3,  7'd0,  8'h55, 2'd0, 1'b1},
        {4'd0,  7'd8,  8'h80, 2'd0, 1'b0},
        {4'd0,  7'd1,  8'h90, 2'd2, 1'b0},
        {4'd15, 7'd1,  8'h91, 2'd1, 1'b0}
    };

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [1:0] code;
        int a0, w0, o0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 req_ready", 256'(req_ready), 256'(1));
        chk("R13 attn", 256'(attn), 256'(0));
        chk("R13 ram_we", 256'(ram_we), 256'(0));
        chk("R13 rsp_valid", 256'(rsp_valid), 256'(0));
        chk("R13 out_valid", 256'(out_valid), 256'(0));
        chk("R13 evt_clr", 256'(evt_clr), 256'(0));

        // table walk: R1 R2 R3 R4 R5
        for (int v = 0; v < 8; v++) begin
            logic [3:0] ch; logic [6:0] ln; logic [7:0] sd; logic [1:0] ec; logic sent;
            string tag;
            {ch, ln, sd, ec, sent} = VEC[v];
            tag = (ec == 2'd1) ? "R4" : (ec == 2'd2) ? "R5" : "R3";
            a0 = attn_n; w0 = wr_n;
            request(1'b0, int'(ch), int'(ln), sd, code);
            chk({tag, " response code"}, 256'(code), 256'(ec));
            wait_idle();
            chk({tag, " R2 attention count"}, 256'(attn_n - a0), 256'(sent));
            chk({tag, " R2 ram write count"}, 256'(wr_n - w0), sent ? 256'(33) : 256'(0));
            if (sent) begin
                chk("R1 R3 send buffer", buf_at(int'(ch) * 32), exp_msg(sd, int'(ln)));
                chk("R2 send state NEW", 256'(mem[512 + int'(ch)]), 256'(1));
            end
        end
        chk("R5 queued message leaves in-flight buffer", buf_at(0), exp_msg(8'h10, 32));

        // R6 R7: completion on ch0 with one message waiting
        fill(0, 8'hA0);
        bwrite(512, 8'h03);
        a0 = attn_n; o0 = out_n;
        raise(2'b01);
        wait_idle();
        chk("R6 one reply", 256'(out_n - o0), 256'(1));
        chk("R6 reply dir", 256'(ev_dir[o0]), 256'(0));
        chk("R6 reply chan", 256'(ev_chan[o0]), 256'(0));
        chk("R6 reply data", ev_data[o0], mk_msg(8'hA0));
        chk("R11 flags cleared", 256'(flags), 256'(0));
        chk("R7 next message state", 256'(mem[512]), 256'(1));
        chk("R7 next message data", buf_at(0), exp_msg(8'h80, 8));
        chk("R7 attention", 256'(attn_n - a0), 256'(1));
        request(1'b0, 0, 2, 8'h70, code);
        chk("R5 slot freed", 256'(code), 256'(0));
        request(1'b0, 0, 2, 8'h71, code);
        chk("R5 full again", 256'(code), 256'(2));
        wait_idle();

        // R8 R9: receive on attached ch1 and unattached ch4
        rx_attach = 7'b0000010;
        fill(256 + 32, 8'h30);
        fill(256 + 128, 8'h60);
        bwrite(521, 8'h01);
        bwrite(524, 8'h01);
        a0 = attn_n; o0 = out_n;
        raise(2'b10);
        wait_idle();
        chk("R8 two messages", 256'(out_n - o0), 256'(2));
        chk("R8 dir", 256'(ev_dir[o0]), 256'(1));
        chk("R12 first chan", 256'(ev_chan[o0]), 256'(1));
        chk("R8 data", ev_data[o0], mk_msg(8'h30));
        chk("R12 second chan", 256'(ev_chan[o0 + 1]), 256'(4));
        chk("R8 state RCVD", 256'(mem[521]), 256'(2));
        chk("R9 state COMPLETE", 256'(mem[524]), 256'(3));
        chk("R9 zero reply", buf_at(256 + 128), 256'(0));
        chk("R9 attention", 256'(attn_n - a0), 256'(1));

        // R10: host completion
        a0 = attn_n;
        request(1'b1, 1, 4, 8'hC0, code);
        chk("R10 code", 256'(code), 256'(0));
        wait_idle();
        chk("R10 state", 256'(mem[521]), 256'(3));
        chk("R10 reply", buf_at(256 + 32), exp_msg(8'hC0, 4));
        chk("R10 attention", 256'(attn_n - a0), 256'(1));
        request(1'b1, 9, 4, 8'hC8, code);
        chk("R4 completion bad chan", 256'(code), 256'(1));

        // R11 R12: both flags, then a late event below the served channel
        fill(192, 8'hE0);
        bwrite(518, 8'h03);
        bwrite(522, 8'h01);
        o0 = out_n;
        raise(2'b11);
        while (out_n < o0 + 2) @(negedge clk);
        bwrite(520, 8'h01);
        raise(2'b10);
        wait_idle();
        chk("R11 three outputs", 256'(out_n - o0), 256'(3));
        chk("R12 send first dir", 256'(ev_dir[o0]), 256'(0));
        chk("R12 send first chan", 256'(ev_chan[o0]), 256'(6));
        chk("R6 ch6 reply", ev_data[o0], mk_msg(8'hE0));
        chk("R12 receive second", 256'({ev_dir[o0 + 1], ev_chan[o0 + 1]}), 256'({1'b1, 4'd2}));
        chk("R11 repeat pass", 256'({ev_dir[o0 + 2], ev_chan[o0 + 2]}), 256'({1'b1, 4'd0}));
        chk("R6 ch6 idle", 256'(mem[518]), 256'(0));
        chk("R9 ch0 complete", 256'(mem[520]), 256'(3));

        summary();
        $finish;
    end
endmodule